// File: doc/BRIEF.md
# Masked CAM Compare Engine

This block stores sixteen 128-bit words, each tagged with a valid bit, and searches all valid words in parallel against a 128-bit comparand. A search key is built up over four 32-bit segment writes. Two 128-bit don't-care masks are loaded the same way. A small configuration register picks mask 1, mask 2 or no mask for the search.

A search starts without any explicit command. Writing the top segment of the comparand or of either mask starts one, and so does any write to the configuration register. One clock later the block registers three results: whether anything hit, whether more than one word hit, and the index of the lowest-numbered hit. These results stay put until the next search.

The hit flag reaches its output pin only while the active-low chain enable is held low. Words are loaded by address, either as valid entries or as invalid ones.

Top module: `maskedCamEngine`

## Requirements
- R1: A write on `ctrlWrEn` starts a search. Its results appear on the outputs after the second rising edge, counting the edge that captures the write.
- R2: A segment write with `segIdx` = 3 (bits 127:96) to the comparand (`segTgt` = 0), mask 1 (`segTgt` = 1) or mask 2 (`segTgt` = 2) starts a search after it is stored. Writes to segments 0–2 do not start one. Segment `segIdx` = k loads bits 32k+31:32k.
- R3: A write with `segTgt` = 3 stores nothing and starts no search.
- R4: Only words whose valid bit is set take part in a search. A word write with `wordValid` = 0 makes that entry invalid.
- R5: `ctrlData` selects the mask as follows: 0 means no mask, 1 means mask 1, 2 means mask 2, and 3 means no mask. A mask bit of 1 makes that bit position a don't-care.
- R6: `matchFlag` equals the registered hit result while `chainEnN` is low, and is 0 while `chainEnN` is high. `multiMatch` is not gated by `chainEnN`.
- R7: `matchAddr` is the lowest index among the matching words, and 0 when no word matches.
- R8: `multiMatch` is 1 exactly when two or more valid words matched in the last search.
- R9: Results hold between searches. Word writes and low-segment writes do not change the outputs.
- R10: After reset, every word is invalid, all registers are zero, no mask is selected and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| segWrEn | input | 1 | Segment write strobe |
| segTgt | input | 2 | Segment target: 0 comparand, 1 mask 1, 2 mask 2, 3 none |
| segIdx | input | 2 | Segment index, 0 = bits 31:0 |
| segData | input | 32 | Segment data |
| ctrlWrEn | input | 1 | Configuration register write strobe |
| ctrlData | input | 2 | Mask select value |
| wordWrEn | input | 1 | Array word write strobe |
| wordAddr | input | 4 | Array word index |
| wordData | input | 128 | Array word contents |
| wordValid | input | 1 | Valid bit stored with the word |
| chainEnN | input | 1 | Active-low gate for the hit flag |
| matchFlag | output | 1 | Gated hit flag |
| multiMatch | output | 1 | More than one word matched |
| matchAddr | output | 4 | Lowest matching word index |

## Verification
The assertions assume that every input is a known value from reset onward, and that each write strobe is sampled only at rising edges. Under those assumptions, the only way to start a search is through the strobes that the control produces from a control write or a top-segment write. The bench drives all inputs at falling edges as one-cycle pulses and returns every strobe to 0 between operations. It never leaves an input undriven after reset. Overlapping writes only occur where a later search is meant to supersede an earlier one.

// File: rtl/camPkg.sv
package camPkg;
  localparam int WordW   = 128;
  localparam int SegW    = 32;
  localparam int Depth   = 16;
  localparam int SegCnt  = WordW / SegW;
  localparam int SegIdxW = $clog2(SegCnt);
  localparam int AddrW   = $clog2(Depth);

  typedef enum logic [1:0] {
    TGT_CMP   = 2'd0,
    TGT_MASK1 = 2'd1,
    TGT_MASK2 = 2'd2,
    TGT_NONE  = 2'd3
  } segTgt_e;

  typedef enum logic [1:0] {
    MSK_OFF  = 2'd0,
    MSK_ONE  = 2'd1,
    MSK_TWO  = 2'd2,
    MSK_OFF2 = 2'd3
  } maskSel_e;

  typedef struct packed {
    logic               ldCmp;
    logic               ldMask1;
    logic               ldMask2;
    logic [SegIdxW-1:0] segIdx;
    logic               ldCtrl;
    logic               compare;
  } camStb_t;
endpackage

// File: rtl/camCtrl.sv
module camCtrl
  import camPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               segWrEn,
  input  logic [1:0]         segTgt,
  input  logic [SegIdxW-1:0] segIdx,
  input  logic               ctrlWrEn,
  output camStb_t            stb
);
  localparam logic [SegIdxW-1:0] LastSeg = SegIdxW'(SegCnt - 1);

  logic trigNow;
  logic compQ;

  assign trigNow = ctrlWrEn ||
                   (segWrEn && segTgt != TGT_NONE && segIdx == LastSeg);

  // Search runs one cycle after the write so it sees the stored value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) compQ <= 1'b0;
    else       compQ <= trigNow;
  end

  always_comb begin
    stb         = '0;
    stb.ldCmp   = segWrEn && segTgt == TGT_CMP;
    stb.ldMask1 = segWrEn && segTgt == TGT_MASK1;
    stb.ldMask2 = segWrEn && segTgt == TGT_MASK2;
    stb.segIdx  = segIdx;
    stb.ldCtrl  = ctrlWrEn;
    stb.compare = compQ;
  end

  // R1
  p_ctrl_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> stb.compare);

  // R2
  p_top_seg_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && segTgt != TGT_NONE && segIdx == LastSeg) |=> stb.compare);

  // R3
  p_no_tgt_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWrEn && (!segWrEn || segTgt == TGT_NONE)) |=> !stb.compare);
endmodule

// File: rtl/camDatapath.sv
module camDatapath
  import camPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  camStb_t          stb,
  input  logic [SegW-1:0]  segData,
  input  logic [1:0]       ctrlData,
  input  logic             wordWrEn,
  input  logic [AddrW-1:0] wordAddr,
  input  logic [WordW-1:0] wordData,
  input  logic             wordValid,
  output logic             hitQ,
  output logic             multiQ,
  output logic [AddrW-1:0] addrQ
);
  logic [WordW-1:0] cmpReg, mask1Reg, mask2Reg, effMask;
  logic [1:0]       maskSelQ;
  logic [WordW-1:0] rowData [Depth];
  logic             rowValid [Depth];
  logic [Depth-1:0] rowHit;
  logic [AddrW-1:0] firstIdx;
  logic             multiNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg   <= '0;
      mask1Reg <= '0;
      mask2Reg <= '0;
      maskSelQ <= MSK_OFF;
    end else begin
      if (stb.ldCmp)   cmpReg[stb.segIdx*SegW +: SegW]   <= segData;
      if (stb.ldMask1) mask1Reg[stb.segIdx*SegW +: SegW] <= segData;
      if (stb.ldMask2) mask2Reg[stb.segIdx*SegW +: SegW] <= segData;
      if (stb.ldCtrl)  maskSelQ <= ctrlData;
    end
  end

  always_comb begin
    case (maskSel_e'(maskSelQ))
      MSK_ONE: effMask = mask1Reg;
      MSK_TWO: effMask = mask2Reg;
      default: effMask = '0;
    endcase
  end

  for (genvar w = 0; w < Depth; w++) begin : gRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowData[w]  <= '0;
        rowValid[w] <= 1'b0;
      end else if (wordWrEn && wordAddr == AddrW'(w)) begin
        rowData[w]  <= wordData;
        rowValid[w] <= wordValid;
      end
    end
    assign rowHit[w] = rowValid[w] &&
                       (((rowData[w] ^ cmpReg) & ~effMask) == '0);
  end

  always_comb begin
    firstIdx = '0;
    for (int i = Depth - 1; i >= 0; i--)
      if (rowHit[i]) firstIdx = AddrW'(i);
  end

  assign multiNext = |(rowHit & (rowHit - Depth'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ   <= 1'b0;
      multiQ <= 1'b0;
      addrQ  <= '0;
    end else if (stb.compare) begin
      hitQ   <= |rowHit;
      multiQ <= multiNext;
      addrQ  <= firstIdx;
    end
  end

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.compare |=> $stable({hitQ, multiQ, addrQ}));

  // R8
  p_multi_has_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    multiQ |-> hitQ);

  // R7
  p_miss_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> addrQ == '0);
endmodule

// File: rtl/maskedCamEngine.sv
module maskedCamEngine
  import camPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               segWrEn,
  input  logic [1:0]         segTgt,
  input  logic [SegIdxW-1:0] segIdx,
  input  logic [SegW-1:0]    segData,
  input  logic               ctrlWrEn,
  input  logic [1:0]         ctrlData,
  input  logic               wordWrEn,
  input  logic [AddrW-1:0]   wordAddr,
  input  logic [WordW-1:0]   wordData,
  input  logic               wordValid,
  input  logic               chainEnN,
  output logic               matchFlag,
  output logic               multiMatch,
  output logic [AddrW-1:0]   matchAddr
);
  camStb_t stb;
  logic    hitQ;

  camCtrl uCtrl (
    .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segTgt(segTgt),
    .segIdx(segIdx), .ctrlWrEn(ctrlWrEn), .stb(stb)
  );

  camDatapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .segData(segData),
    .ctrlData(ctrlData), .wordWrEn(wordWrEn), .wordAddr(wordAddr),
    .wordData(wordData), .wordValid(wordValid), .hitQ(hitQ),
    .multiQ(multiMatch), .addrQ(matchAddr)
  );

  assign matchFlag = hitQ & ~chainEnN;

  // R6
  p_flag_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    chainEnN |-> !matchFlag);
endmodule

// File: tb/maskedCamEngine_test.sv
module maskedCamEngine_test;
  logic         clk = 0;
  logic         rstN = 0;
  logic         segWrEn = 0;
  logic [1:0]   segTgt = 0;
  logic [1:0]   segIdx = 0;
  logic [31:0]  segData = 0;
  logic         ctrlWrEn = 0;
  logic [1:0]   ctrlData = 0;
  logic         wordWrEn = 0;
  logic [3:0]   wordAddr = 0;
  logic [127:0] wordData = 0;
  logic         wordValid = 0;
  logic         chainEnN = 0;
  logic         matchFlag, multiMatch;
  logic [3:0]   matchAddr;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  maskedCamEngine uut (
    .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segTgt(segTgt),
    .segIdx(segIdx), .segData(segData), .ctrlWrEn(ctrlWrEn),
    .ctrlData(ctrlData), .wordWrEn(wordWrEn), .wordAddr(wordAddr),
    .wordData(wordData), .wordValid(wordValid), .chainEnN(chainEnN),
    .matchFlag(matchFlag), .multiMatch(multiMatch), .matchAddr(matchAddr)
  );

  localparam logic [127:0] KA = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] KB = 128'h11111111_22222222_33333333_44445555;
  localparam logic [127:0] KC = {128{1'b1}};
  localparam logic [127:0] KD = 128'h11111111_22222222_33333333_44446666;

  typedef struct packed {
    logic [127:0] key;
    logic [1:0]   sel;
    logic         hit;
    logic         multi;
    logic [3:0]   addr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{KA, 2'd0, 1'b1, 1'b1, 4'd2},
    '{KB, 2'd0, 1'b1, 1'b0, 4'd5},
    '{KB, 2'd1, 1'b1, 1'b1, 4'd2},
    '{KC, 2'd0, 1'b0, 1'b0, 4'd0},
    '{KC, 2'd2, 1'b1, 1'b1, 4'd2},
    '{KC, 2'd3, 1'b0, 1'b0, 4'd0},
    '{KD, 2'd1, 1'b1, 1'b1, 4'd2},
    '{KD, 2'd0, 1'b0, 1'b0, 4'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic f,
                        input logic m, input logic [3:0] a);
    chk(req, "matchFlag", 32'(matchFlag), 32'(f));
    chk(req, "multiMatch", 32'(multiMatch), 32'(m));
    chk(req, "matchAddr", 32'(matchAddr), 32'(a));
  endtask

  task automatic writeSeg(input logic [1:0] tgt, input logic [1:0] idx,
                          input logic [31:0] d);
    @(negedge clk);
    segWrEn = 1; segTgt = tgt; segIdx = idx; segData = d;
    @(negedge clk);
    segWrEn = 0;
  endtask

  task automatic loadWide(input logic [1:0] tgt, input logic [127:0] v);
    for (int s = 0; s < 4; s++) writeSeg(tgt, 2'(s), v[s*32 +: 32]);
  endtask

  task automatic writeCtrl(input logic [1:0] sel);
    @(negedge clk);
    ctrlWrEn = 1; ctrlData = sel;
    @(negedge clk);
    ctrlWrEn = 0;
  endtask

  task automatic writeWord(input logic [3:0] a, input logic [127:0] d,
                           input logic v);
    @(negedge clk);
    wordWrEn = 1; wordAddr = a; wordData = d; wordValid = v;
    @(negedge clk);
    wordWrEn = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    settle();
    chkAll("R10 reset", 1'b0, 1'b0, 4'd0);

    writeWord(4'd2, KA, 1'b1);
    writeWord(4'd5, KB, 1'b1);
    writeWord(4'd9, KA, 1'b1);
    writeWord(4'd12, KC, 1'b1);
    writeWord(4'd12, KC, 1'b0);                           // R4 invalidate
    loadWide(2'd1, 128'h0000FFFF);
    loadWide(2'd2, KC);

    // R1 R5 R7 R8 table walk; R4 word 12 must never hit
    for (int i = 0; i < 8; i++) begin
      loadWide(2'd0, VECS[i].key);
      writeCtrl(VECS[i].sel);
      settle();
      chkAll($sformatf("R5 vec%0d", i), VECS[i].hit, VECS[i].multi, VECS[i].addr);
    end

    // R6 gating of the hit flag
    loadWide(2'd0, KA);
    writeCtrl(2'd0);
    settle();
    chainEnN = 1;
    #1;
    chkAll("R6 gated", 1'b0, 1'b1, 4'd2);
    chainEnN = 0;
    #1;
    chkAll("R6 ungated", 1'b1, 1'b1, 4'd2);

    // R2 / R9: low segment write does not search
    writeSeg(2'd0, 2'd0, 32'h44445555);
    settle();
    chkAll("R2 low seg", 1'b1, 1'b1, 4'd2);
    writeSeg(2'd0, 2'd3, 32'h11111111);
    settle();
    chkAll("R2 top seg", 1'b1, 1'b0, 4'd5);

    // R9 word write holds results; R3 target none ignored
    writeWord(4'd3, KB, 1'b1);
    settle();
    chkAll("R9 word hold", 1'b1, 1'b0, 4'd5);
    writeSeg(2'd3, 2'd3, 32'h0);
    settle();
    chkAll("R3 none tgt", 1'b1, 1'b0, 4'd5);
    writeCtrl(2'd0);
    settle();
    chkAll("R1 ctrl search", 1'b1, 1'b1, 4'd3);

    // R4 clearing words
    writeWord(4'd3, KB, 1'b0);
    writeWord(4'd5, KB, 1'b0);
    writeCtrl(2'd0);
    settle();
    chkAll("R4 invalid", 1'b0, 1'b0, 4'd0);

    // R7 top index
    writeWord(4'd15, KB, 1'b1);
    writeCtrl(2'd0);
    settle();
    chkAll("R7 index15", 1'b1, 1'b0, 4'd15);

    // R2 mask top segment also starts a search
    writeWord(4'd0, KB, 1'b1);
    settle();
    chkAll("R9 hold2", 1'b1, 1'b0, 4'd15);
    writeSeg(2'd1, 2'd3, 32'h0);
    settle();
    chkAll("R2 mask seg3", 1'b1, 1'b1, 4'd0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule